// File: doc/BRIEF.md
# Serially Programmed Clock Fan-Out Gate

This block fans one reference clock out to thirteen output clocks. Each output can be switched on or off through a two-wire serial write port. The serial side is a write-only target. It oversamples SCL and SDA with a local system clock and answers on SDA through an open-drain pull-down. It holds no sub-address pointer. After its own address and two dummy bytes, the data bytes load the three enable registers in a fixed order. A write that changes a later register must therefore resend the earlier ones.

On the clock side, each output's enable bit is resynchronised to the reference clock and applied only while the reference is low. An output that is switched off stops in its low state. An output that is switched on starts with a whole high phase. After reset every output runs.

Top module: `clkfan_gate_ctl`

## Requirements
- R1: After reset all 13 outputs follow the reference clock.
- R2: An address byte of 0xD2 (address 1101001, write bit 0) is acknowledged. Any other first byte, including 0xD3, is not acknowledged. Bytes that follow a refused address are neither acknowledged nor stored.
- R3: After 0xD2, the next two bytes are acknowledged and their values are discarded.
- R4: The 4th, 5th and 6th bytes after a start are stored as enable registers A, B and C, in that order. Bytes are sent MSB first. A write that stops early changes only the registers it reached.
- R5: The registers map to outputs as follows:
  - Register A bit n (n = 0..7) enables output n.
  - Register B bits 0..2 enable outputs 10..12.
  - Register C bit 6 enables output 8 and bit 7 enables output 9.
  - All other bits are ignored.
  - A bit value of 1 means the output is enabled.
- R6: Bytes after the 6th are acknowledged and discarded.
- R7: A repeated start restarts address reception. After a stop, bytes are ignored until the next start.
- R8: An enabled output is high while the reference is high and low while it is low. A disabled output is held low.
- R9: An output changes its enable only while the reference is low, so no high phase is ever cut short.
- R10: The acknowledge pull-down is asserted and released only while SCL is low, and it is released by a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line (resolved bus level) |
| sda_pd_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| ref_clk_i | input | 1 | Reference clock to be fanned out |
| clk_o | output | 13 | Gated copies of the reference clock |

## Verification
A vector table writes enable patterns that separate the outputs from each other: all off, alternating bits, reserved bits set against cleared enables, and writes that stop after one or two data bytes. These patterns show that each output is mapped to the right register bit and that early stops leave the later registers alone. Directed sequences use foreign and read addresses, surplus bytes, a repeated start, and bytes sent after a stop. These sequences distinguish a refused address from an accepted one, and show that the dummy bytes and the surplus bytes cannot reach the registers. Each output is sampled twice in one high phase and once in the low phase, which shows both gating and high-phase stability.

// File: rtl/clkfan_gate_ctl.sv
module clkfan_gate_ctl #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NOUT     = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_pd_o,
  input  logic            ref_clk_i,
  output logic [NOUT-1:0] clk_o
);
  localparam logic [7:0] ADDR_WR = {DEV_ADDR, 1'b0};
  localparam int         IDX_W   = 3;

  logic [2:0] scl_sh, sda_sh;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end

  wire scl_n = scl_sh[1], scl_q = scl_sh[2];
  wire sda_n = sda_sh[1], sda_q = sda_sh[2];
  wire start_det = scl_n & scl_q & sda_q & ~sda_n;
  wire stop_det  = scl_n & scl_q & ~sda_q & sda_n;
  wire scl_rise  = scl_n & ~scl_q;
  wire scl_fall  = ~scl_n & scl_q;

  logic             busy, in_ack;
  logic [3:0]       bitcnt;
  logic [IDX_W-1:0] idx;
  logic [7:0]       shreg, reg_a, reg_b, reg_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy     <= 1'b0;
      in_ack   <= 1'b0;
      bitcnt   <= '0;
      idx      <= '0;
      shreg    <= '0;
      sda_pd_o <= 1'b0;
      reg_a    <= 8'hFF;
      reg_b    <= 8'h07;
      reg_c    <= 8'hC0;
    end else if (start_det) begin
      busy     <= 1'b1;
      in_ack   <= 1'b0;
      bitcnt   <= '0;
      idx      <= '0;
      sda_pd_o <= 1'b0;
    end else if (stop_det) begin
      busy     <= 1'b0;
      in_ack   <= 1'b0;
      sda_pd_o <= 1'b0;
    end else if (busy) begin
      if (scl_rise && !in_ack && bitcnt != 4'd8) begin
        shreg  <= {shreg[6:0], sda_n};
        bitcnt <= bitcnt + 4'd1;
      end
      if (scl_fall) begin
        if (in_ack) begin
          in_ack   <= 1'b0;
          sda_pd_o <= 1'b0;
          bitcnt   <= '0;
        end else if (bitcnt == 4'd8) begin
          if (idx == '0) begin
            if (shreg == ADDR_WR) begin
              in_ack   <= 1'b1;
              sda_pd_o <= 1'b1;
              idx      <= idx + 1'b1;
            end else begin
              busy <= 1'b0;
            end
          end else begin
            in_ack   <= 1'b1;
            sda_pd_o <= 1'b1;
            if (idx != '1) idx <= idx + 1'b1;
            case (idx)
              3'd3:    reg_a <= shreg;
              3'd4:    reg_b <= shreg;
              3'd5:    reg_c <= shreg;
              default: ;
            endcase
          end
        end
      end
    end

  logic [NOUT-1:0] en_sys, en_meta, en_sync, gate_q;
  assign en_sys = {reg_b[2:0], reg_c[7], reg_c[6], reg_a};

  always_ff @(posedge ref_clk_i or negedge rst_n)
    if (!rst_n) begin
      en_meta <= '1;
      en_sync <= '1;
    end else begin
      en_meta <= en_sys;
      en_sync <= en_meta;
    end

  always_ff @(negedge ref_clk_i or negedge rst_n)
    if (!rst_n) gate_q <= '1;
    else        gate_q <= en_sync;

  assign clk_o = {NOUT{ref_clk_i}} & gate_q;
endmodule

// File: rtl/clkfan_gate_chk.sv
module clkfan_gate_chk #(
  parameter int NOUT = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_i,
  input logic            sda_pd_o,
  input logic            stop_seen,
  input logic            ref_clk_i,
  input logic [NOUT-1:0] clk_o
);
  AST_PD_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pd_o) |-> !scl_i); // R10
  AST_PD_RELEASED_BY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !sda_pd_o); // R10
  AST_LOW_WHEN_REF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_clk_i |-> (clk_o == '0)); // R8
  AST_STABLE_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_clk_i && $past(ref_clk_i)) |-> $stable(clk_o)); // R9
endmodule

bind clkfan_gate_ctl clkfan_gate_chk #(.NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pd_o(sda_pd_o),
  .stop_seen(stop_det), .ref_clk_i(ref_clk_i), .clk_o(clk_o));

// File: tb/sim_clkfan_gate_ctl.sv
`timescale 1ns/1ps
module sim_clkfan_gate_ctl;
  localparam int Q = 40;
  logic clk = 0, ref_clk = 0, rst_n = 0;
  logic scl = 1, sda_drv = 1;
  logic sda_pd;
  logic [12:0] clk_o;
  wire sda_line = sda_drv & ~sda_pd;
  int n_chk = 0, n_fail = 0;
  logic [7:0] sh_a = 8'hFF, sh_b = 8'h07, sh_c = 8'hC0;

  always #2.5 clk = ~clk;
  always #8 ref_clk = ~ref_clk;

  clkfan_gate_ctl u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pd_o(sda_pd), .ref_clk_i(ref_clk), .clk_o(clk_o));

  localparam logic [26:0] VEC [6] = '{
    {3'd3, 8'h00, 8'h00, 8'h00},
    {3'd3, 8'h55, 8'h05, 8'h80},
    {3'd3, 8'hAA, 8'hFA, 8'h40},
    {3'd1, 8'hFF, 8'h00, 8'h00},
    {3'd2, 8'h0F, 8'h07, 8'h00},
    {3'd3, 8'hFF, 8'h07, 8'hC0}};

  function automatic logic [12:0] emask(input logic [7:0] a, b, c);
    return {b[2:0], c[7], c[6], a};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic i2c_start();
    sda_drv = 1; #Q scl = 1; #Q sda_drv = 0; #Q scl = 0; #Q;
  endtask

  task automatic i2c_stop();
    sda_drv = 0; #Q scl = 1; #Q sda_drv = 1; #Q;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; #Q scl = 1; #(2*Q) scl = 0; #Q;
    end
    sda_drv = 1; #Q scl = 1; #Q a1 = !sda_line; #(Q-5) a2 = !sda_line; #5 scl = 0; #Q;
    chk(req, a1, exp_ack);
    chk("R10 ack held through high phase", a2, a1);
  endtask

  task automatic chk_out(input string req);
    logic [12:0] e, h1, h2, l1;
    e = emask(sh_a, sh_b, sh_c);
    repeat (5) @(posedge ref_clk);
    #2 h1 = clk_o; #4 h2 = clk_o;
    @(negedge ref_clk); #4 l1 = clk_o;
    chk({req, " R8 high"}, h1, e);
    chk("R9 high phase stable", h2, h1);
    chk("R8 low phase", l1, 13'h0);
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #23 rst_n = 1;
    #200;
    chk_out("R1 reset all on");

    foreach (VEC[k]) begin
      logic [2:0] n;
      n = VEC[k][26:24];
      i2c_start();
      send_byte(8'hD2, 1, "R2 address ack");
      send_byte(8'hFF ^ 8'(k), 1, "R3 command ack");
      send_byte(8'h3C + 8'(k), 1, "R3 count ack");
      send_byte(VEC[k][23:16], 1, "R4 byte A ack");
      sh_a = VEC[k][23:16];
      if (n > 1) begin send_byte(VEC[k][15:8], 1, "R4 byte B ack"); sh_b = VEC[k][15:8]; end
      if (n > 2) begin send_byte(VEC[k][7:0], 1, "R4 byte C ack"); sh_c = VEC[k][7:0]; end
      i2c_stop();
      chk_out("R5 map / R4 order");
    end

    i2c_start();
    send_byte(8'hA4, 0, "R2 foreign address nack");
    send_byte(8'h00, 0, "R2 no ack after refusal");
    i2c_stop();
    chk_out("R2 foreign no change");

    i2c_start();
    send_byte(8'hD3, 0, "R2 read address nack");
    send_byte(8'h00, 0, "R2 no ack after read");
    send_byte(8'h00, 0, "R2 no ack after read");
    send_byte(8'h00, 0, "R2 no ack after read");
    i2c_stop();
    chk_out("R2 read no change");

    i2c_start();
    send_byte(8'hD2, 1, "R2 address ack");
    send_byte(8'h00, 1, "R3 command ack");
    send_byte(8'h00, 1, "R3 count ack");
    send_byte(8'h3C, 1, "R4 byte A ack");
    send_byte(8'h03, 1, "R4 byte B ack");
    send_byte(8'h40, 1, "R4 byte C ack");
    send_byte(8'h00, 1, "R6 surplus ack");
    send_byte(8'h00, 1, "R6 surplus ack");
    i2c_stop();
    sh_a = 8'h3C; sh_b = 8'h03; sh_c = 8'h40;
    chk_out("R6 surplus discarded");

    i2c_start();
    send_byte(8'hD2, 1, "R7 address ack");
    send_byte(8'h00, 1, "R7 command ack");
    send_byte(8'h00, 1, "R7 count ack");
    send_byte(8'h11, 1, "R7 byte A ack");
    i2c_start();
    send_byte(8'hD2, 1, "R7 restart address ack");
    send_byte(8'h00, 1, "R7 command ack");
    send_byte(8'h00, 1, "R7 count ack");
    send_byte(8'h22, 1, "R7 byte A ack");
    i2c_stop();
    sh_a = 8'h22;
    chk_out("R7 repeated start");

    send_byte(8'hD2, 0, "R7 idle after stop nack");
    send_byte(8'h00, 0, "R7 idle after stop nack");
    i2c_stop();
    chk_out("R7 idle no change");

    rst_n = 0; #30 rst_n = 1; #100;
    sh_a = 8'hFF; sh_b = 8'h07; sh_c = 8'hC0;
    chk_out("R1 reset restores all on");

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule